// File: doc/BRIEF.md
# Memory-Mapped Request Executor

This block turns one framed request, delivered as a byte stream with start and end markers, into word accesses on a simple memory-mapped master port. It then produces the matching response as a byte stream. Escaping and framing have already been removed upstream. The block sees clean bytes plus a start flag and an end flag on each byte.

Every request begins with an eight-byte header. The header fields appear in this order:

- an opcode byte
- a reserved byte, which is ignored
- a 16-bit byte count, most significant byte first
- a 32-bit address, most significant byte first

A write request carries one 32-bit payload word after the header, least significant byte first. A read request ends right after the header.

Reads return only the data words, with no header. Writes return a short four-byte acknowledgement. A request that cannot be executed is thrown away without touching the bus, and a sticky error flag records the event.

The master port holds its address, strobes and write data stable while `busWait` is high. It keeps at most one read outstanding, and returned data is taken when `busRdValid` is high. While a request is being checked, executed or answered, the input is not accepted (`inReady` low). The response stream has no back-pressure: one byte leaves on every cycle of a response word.

Top module: `txexec_top`

## Requirements
- R1: After the header, the bus address of the first access equals the 32-bit header address read most significant byte first (bytes 5 to 8), and the 16-bit byte count is bytes 3 and 4, most significant byte first.
- R2: Opcode 0x00 (single write) or 0x04 (incrementing write) with count 4 and exactly four payload bytes causes one bus write. Its write data is the payload with the first payload byte in bits 7:0.
- R3: After a write is accepted, the response is four bytes: request opcode OR 0x80, then 0x00, then the count high byte, then the count low byte. The start flag is on the first byte and the end flag on the fourth.
- R4: Opcode 0x10 (single read) with count 4 causes one bus read. The captured word is returned as four bytes, least significant first, with the start flag on the first byte, the end flag on the last, and no header.
- R5: Opcode 0x14 (incrementing read) with count 4N performs N reads at address, address+4, address+8 and so on. It returns the 4N data bytes in access order, with a single start flag on the first byte and a single end flag on the last.
- R6: While `busWait` is high, an active `busRead` or `busWrite` stays asserted and `busAddr` and `busWdata` stay unchanged. Read and write are never asserted together.
- R7: A read count of zero, a count that is not a multiple of 4, an incrementing-read count above 1024, a single-read count other than 4, or a write count other than 4 drops the request with no bus access and no response.
- R8: Opcode 0x7F, or any opcode other than 0x00, 0x04, 0x10 and 0x14, drops the request with no bus access and no response.
- R9: A packet whose end flag does not fall exactly on its last expected byte is dropped with no bus access and no response. The last expected byte is byte 8 for reads and byte 12 for writes. Bytes after the drop point are ignored until the next start flag.
- R10: Bytes with no start flag arriving between packets are ignored. A start flag in the middle of a header or payload restarts parsing with that byte as a new opcode.
- R11: Dropped requests (R7, R8, R9) set `errFlag`, which is 0 after reset and stays 1 until reset. `inReady` is 1 when idle and 0 while the bus is driven or a response is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte |
| inSop | input | 1 | Byte is first of a packet |
| inEop | input | 1 | Byte is last of a packet |
| inReady | output | 1 | Input byte is taken this cycle |
| busAddr | output | ADDR_W | Bus word address |
| busRead | output | 1 | Read strobe |
| busWrite | output | 1 | Write strobe |
| busWdata | output | 32 | Write data |
| busWait | input | 1 | Slave stalls the current access |
| busRdata | input | 32 | Read data |
| busRdValid | input | 1 | Read data present |
| outValid | output | 1 | Response byte present |
| outData | output | 8 | Response byte |
| outSop | output | 1 | First response byte |
| outEop | output | 1 | Last response byte |
| errFlag | output | 1 | Sticky dropped-request flag |

## Verification
A corrupted header register or address counter shows up at the first bus acceptance after the header, as a wrong address, kind or write word. A wrong word counter or byte selector shows up within four cycles of the read data returning, as a misordered or misflagged response byte. A parser that loses its place shows up either as a bus access for a packet that should have been dropped, or as a missing access and a set error flag for a good packet. The bench sees either case by the end of that packet.

// File: rtl/txexec_pkg.sv
package txexec_pkg;

  localparam logic [7:0] OP_WR     = 8'h00;
  localparam logic [7:0] OP_WR_INC = 8'h04;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_RD_INC = 8'h14;

  // strobes from control to datapath
  typedef struct packed {
    logic       capOp;
    logic       capHdr;
    logic       capWd;
    logic       loadRun;
    logic       stepWord;
    logic       capRd;
    logic [1:0] byteSel;
  } ctlStrobes_t;

  // decoded state returned by the datapath
  typedef struct packed {
    logic [7:0]  opcode;
    logic [15:0] byteCount;
    logic        lastWord;
  } dpStatus_t;

endpackage

// File: rtl/txexec_dpath.sv
module txexec_dpath
  import txexec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int MAX_RD_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [7:0]        inData,
  input  logic [31:0]       busRdata,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic [7:0]        outData
);

  localparam int WL_W      = $clog2(MAX_RD_WORDS + 1);
  localparam int WORD_STEP = 4;

  logic [7:0]        opReg;
  logic [47:0]       hdrSr;     // count and address, big-endian shift
  logic [31:0]       wdReg;
  logic [31:0]       rdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [WL_W-1:0]   wordsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg     <= '0;
      hdrSr     <= '0;
      wdReg     <= '0;
      rdReg     <= '0;
      addrReg   <= '0;
      wordsLeft <= '0;
    end else begin
      if (ctl.capOp)  opReg <= inData;
      if (ctl.capHdr) hdrSr <= {hdrSr[39:0], inData};
      if (ctl.capWd)  wdReg <= {inData, wdReg[31:8]};
      if (ctl.capRd)  rdReg <= busRdata;
      if (ctl.loadRun) begin
        addrReg   <= hdrSr[ADDR_W-1:0];
        wordsLeft <= WL_W'(hdrSr[47:34]);
      end else if (ctl.stepWord) begin
        if (opReg[2]) addrReg <= addrReg + ADDR_W'(WORD_STEP);
        wordsLeft <= wordsLeft - 1'b1;
      end
    end
  end

  always_comb begin
    status.opcode    = opReg;
    status.byteCount = hdrSr[47:32];
    status.lastWord  = (wordsLeft == '0);
  end

  assign busAddr  = addrReg;
  assign busWdata = wdReg;

  // read data goes out LSB first; write acknowledge is a 4-byte header
  always_comb begin
    if (opReg[4]) begin
      outData = rdReg[8*ctl.byteSel +: 8];
    end else begin
      case (ctl.byteSel)
        2'd0:    outData = opReg | 8'h80;
        2'd1:    outData = 8'h00;
        2'd2:    outData = hdrSr[47:40];
        default: outData = hdrSr[39:32];
      endcase
    end
  end

endmodule

// File: rtl/txexec_ctrl.sv
module txexec_ctrl
  import txexec_pkg::*;
#(
  parameter int MAX_RD_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSop,
  input  logic        inEop,
  output logic        inReady,
  input  logic        busWait,
  input  logic        busRdValid,
  output logic        busRead,
  output logic        busWrite,
  output logic        outValid,
  output logic        outSop,
  output logic        outEop,
  output logic        errFlag,
  input  dpStatus_t   status,
  output ctlStrobes_t ctl
);

  localparam logic [15:0] MAX_RD_BYTES = 16'(4 * MAX_RD_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CHECK, ST_WDATA, ST_BUSWR, ST_BUSRD, ST_RDWAIT, ST_SEND
  } state_t;

  state_t     state, stateN;
  logic [2:0] byteCnt, byteCntN;
  logic       eopAt8, eopAt8N;
  logic       firstOut, firstOutN;
  logic       errReg, errSet;
  logic       cntAligned, rdOk, wrOk;

  always_comb begin
    cntAligned = (status.byteCount[1:0] == 2'b00) && (status.byteCount != 16'd0);
    rdOk = ((status.opcode == OP_RD) && (status.byteCount == 16'd4)) ||
           ((status.opcode == OP_RD_INC) && cntAligned && (status.byteCount <= MAX_RD_BYTES));
    wrOk = ((status.opcode == OP_WR) || (status.opcode == OP_WR_INC)) &&
           (status.byteCount == 16'd4);
  end

  always_comb begin
    stateN      = state;
    byteCntN    = byteCnt;
    eopAt8N     = eopAt8;
    firstOutN   = firstOut;
    errSet      = 1'b0;
    ctl         = '0;
    ctl.byteSel = byteCnt[1:0];
    case (state)
      ST_IDLE: begin
        if (inValid && inSop) begin
          ctl.capOp = 1'b1;
          if (inEop) errSet = 1'b1;
          else begin
            stateN   = ST_HDR;
            byteCntN = 3'd1;
          end
        end
      end
      ST_HDR: begin
        if (inValid) begin
          if (inSop) begin
            ctl.capOp = 1'b1;
            byteCntN  = 3'd1;
            if (inEop) begin
              errSet = 1'b1;
              stateN = ST_IDLE;
            end
          end else begin
            ctl.capHdr = 1'b1;
            if (byteCnt == 3'd7) begin
              eopAt8N = inEop;
              stateN  = ST_CHECK;
            end else if (inEop) begin
              errSet = 1'b1;
              stateN = ST_IDLE;
            end else begin
              byteCntN = byteCnt + 3'd1;
            end
          end
        end
      end
      ST_CHECK: begin
        if (rdOk && eopAt8) begin
          ctl.loadRun = 1'b1;
          firstOutN   = 1'b1;
          stateN      = ST_BUSRD;
        end else if (wrOk && !eopAt8) begin
          ctl.loadRun = 1'b1;
          firstOutN   = 1'b1;
          byteCntN    = 3'd0;
          stateN      = ST_WDATA;
        end else begin
          errSet = 1'b1;
          stateN = ST_IDLE;
        end
      end
      ST_WDATA: begin
        if (inValid) begin
          if (inSop) begin
            ctl.capOp = 1'b1;
            byteCntN  = 3'd1;
            if (inEop) begin
              errSet = 1'b1;
              stateN = ST_IDLE;
            end else begin
              stateN = ST_HDR;
            end
          end else begin
            ctl.capWd = 1'b1;
            if (byteCnt == 3'd3) begin
              if (inEop) stateN = ST_BUSWR;
              else begin
                errSet = 1'b1;
                stateN = ST_IDLE;
              end
            end else if (inEop) begin
              errSet = 1'b1;
              stateN = ST_IDLE;
            end else begin
              byteCntN = byteCnt + 3'd1;
            end
          end
        end
      end
      ST_BUSWR: begin
        if (!busWait) begin
          ctl.stepWord = 1'b1;
          byteCntN     = 3'd0;
          stateN       = ST_SEND;
        end
      end
      ST_BUSRD: begin
        if (!busWait) begin
          ctl.stepWord = 1'b1;
          stateN       = ST_RDWAIT;
        end
      end
      ST_RDWAIT: begin
        if (busRdValid) begin
          ctl.capRd = 1'b1;
          byteCntN  = 3'd0;
          stateN    = ST_SEND;
        end
      end
      ST_SEND: begin
        firstOutN = 1'b0;
        if (byteCnt == 3'd3) stateN = status.lastWord ? ST_IDLE : ST_BUSRD;
        else byteCntN = byteCnt + 3'd1;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteCnt  <= '0;
      eopAt8   <= 1'b0;
      firstOut <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      state    <= stateN;
      byteCnt  <= byteCntN;
      eopAt8   <= eopAt8N;
      firstOut <= firstOutN;
      errReg   <= errReg | errSet;
    end
  end

  assign inReady  = (state == ST_IDLE) || (state == ST_HDR) || (state == ST_WDATA);
  assign busRead  = (state == ST_BUSRD);
  assign busWrite = (state == ST_BUSWR);
  assign outValid = (state == ST_SEND);
  assign outSop   = (state == ST_SEND) && firstOut && (byteCnt == 3'd0);
  assign outEop   = (state == ST_SEND) && (byteCnt == 3'd3) && status.lastWord;
  assign errFlag  = errReg;

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8
  bad_req_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !(rdOk && eopAt8) && !(wrOk && !eopAt8))
      |=> (!busRead && !busWrite && errFlag));

endmodule

// File: rtl/txexec_top.sv
module txexec_top
  import txexec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int MAX_RD_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              inReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic              busWrite,
  output logic [31:0]       busWdata,
  input  logic              busWait,
  input  logic [31:0]       busRdata,
  input  logic              busRdValid,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outSop,
  output logic              outEop,
  output logic              errFlag
);

  ctlStrobes_t ctl;
  dpStatus_t   status;

  txexec_ctrl #(.MAX_RD_WORDS(MAX_RD_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSop(inSop), .inEop(inEop), .inReady(inReady),
    .busWait(busWait), .busRdValid(busRdValid),
    .busRead(busRead), .busWrite(busWrite),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .errFlag(errFlag), .status(status), .ctl(ctl)
  );

  txexec_dpath #(.ADDR_W(ADDR_W), .MAX_RD_WORDS(MAX_RD_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .inData(inData), .busRdata(busRdata), .status(status),
    .busAddr(busAddr), .busWdata(busWdata), .outData(outData)
  );

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busWait) |=> (busRead && $stable(busAddr)));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busWait) |=> (busWrite && $stable(busAddr) && $stable(busWdata)));

  // R3
  resp_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEop) |=> !outValid);

endmodule

// File: tb/txexec_top_tb_top.sv
module txexec_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady;
  logic [31:0] busAddr, busWdata;
  logic        busRead, busWrite;
  logic        busWait = 1'b0, busRdValid = 1'b0;
  logic [31:0] busRdata = 32'h0;
  logic        outValid, outSop, outEop, errFlag;
  logic [7:0]  outData;

  always #10 clk = ~clk;

  txexec_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSop(inSop),
    .inEop(inEop), .inReady(inReady), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busWait(busWait),
    .busRdata(busRdata), .busRdValid(busRdValid), .outValid(outValid),
    .outData(outData), .outSop(outSop), .outEop(outEop), .errFlag(errFlag)
  );

  int   checks = 0, fails = 0;
  bit   finished = 1'b0;
  bit   expErr = 1'b0;
  bit   expBusWr[$];
  logic [31:0] expBusAddr[$], expBusData[$];
  logic [10:0] expOut[$];          // {isWriteAck, sop, eop, data}
  logic [31:0] modelMem[logic [31:0]];
  logic [31:0] slaveMem[logic [31:0]];
  logic [7:0]  pkt[$];
  logic [15:0] lfsr = 16'hACE1;
  bit   pendRd = 1'b0;
  int   rdCnt = 0;
  logic [31:0] pendData;
  bit   prevRd = 1'b0, prevWr = 1'b0, prevWait = 1'b0;
  logic [31:0] prevAddr, prevWd;

  function automatic logic [31:0] seedData(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison and bus slave, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevRd && prevWait) check(busRead && busAddr == prevAddr, "R6", "read held", busAddr, prevAddr);
      if (prevWr && prevWait) check(busWrite && busAddr == prevAddr && busWdata == prevWd, "R6", "write held", busWdata, prevWd);
      check(!(busRead && busWrite), "R6", "one strobe", {busRead, busWrite}, 0);
      if (busRead || busWrite || outValid) check(!inReady, "R11", "inReady low busy", inReady, 0);

      busRdValid = 1'b0;
      if (pendRd) begin
        if (rdCnt == 0) begin
          busRdValid = 1'b1;
          busRdata = pendData;
          pendRd = 1'b0;
        end else rdCnt--;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busWait = lfsr[0] & lfsr[3];

      if ((busRead || busWrite) && !busWait) begin
        if (expBusWr.size() == 0) begin
          check(1'b0, "R8", "unexpected bus access", busAddr, 0);
        end else begin
          bit eW; logic [31:0] eA, eD;
          eW = expBusWr.pop_front(); eA = expBusAddr.pop_front(); eD = expBusData.pop_front();
          check(busAddr == eA, eW ? "R1" : "R5", "bus address", busAddr, eA);
          check(busWrite == eW, eW ? "R2" : "R4", "bus kind", busWrite, eW);
          if (eW) check(busWdata == eD, "R2", "write data", busWdata, eD);
        end
        if (busWrite) slaveMem[busAddr] = busWdata;
        else begin
          pendRd = 1'b1;
          rdCnt = lfsr[5];
          pendData = slaveMem.exists(busAddr) ? slaveMem[busAddr] : seedData(busAddr);
        end
      end
      prevRd = busRead; prevWr = busWrite; prevWait = busWait;
      prevAddr = busAddr; prevWd = busWdata;

      if (outValid) begin
        if (expOut.size() == 0) begin
          check(1'b0, "R8", "unexpected response byte", outData, 0);
        end else begin
          logic [10:0] e;
          e = expOut.pop_front();
          check({outSop, outEop, outData} == e[9:0], e[10] ? "R3" : "R5",
                "response byte", {outSop, outEop, outData}, e[9:0]);
        end
      end
    end
  end

  task automatic sendByte(logic [7:0] b, bit s, bit e);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = b; inSop = s; inEop = e;
    @(posedge clk);
    #1;
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic sendPkt();
    for (int i = 0; i < pkt.size(); i++) sendByte(pkt[i], i == 0, i == pkt.size() - 1);
  endtask

  task automatic buildHdr(logic [7:0] op, logic [15:0] cnt, logic [31:0] addr);
    pkt = {op, 8'h00, cnt[15:8], cnt[7:0], addr[31:24], addr[23:16], addr[15:8], addr[7:0]};
  endtask

  task automatic waitDone();
    do @(negedge clk);
    while (!(expBusWr.size() == 0 && expOut.size() == 0 && inReady && !outValid && !pendRd));
    repeat (3) @(negedge clk);
  endtask

  task automatic runValid(logic [7:0] op, logic [15:0] cnt, logic [31:0] addr, logic [31:0] wd);
    buildHdr(op, cnt, addr);
    if (op[4] == 1'b0) begin
      pkt.push_back(wd[7:0]); pkt.push_back(wd[15:8]);
      pkt.push_back(wd[23:16]); pkt.push_back(wd[31:24]);
      expBusWr.push_back(1'b1); expBusAddr.push_back(addr); expBusData.push_back(wd);
      modelMem[addr] = wd;
      expOut.push_back({1'b1, 1'b1, 1'b0, op | 8'h80});
      expOut.push_back({1'b1, 1'b0, 1'b0, 8'h00});
      expOut.push_back({1'b1, 1'b0, 1'b0, cnt[15:8]});
      expOut.push_back({1'b1, 1'b0, 1'b1, cnt[7:0]});
    end else begin
      int words = cnt / 4;
      for (int k = 0; k < words; k++) begin
        logic [31:0] a, d;
        a = addr + ((op == 8'h14) ? 32'(4 * k) : 32'h0);
        d = modelMem.exists(a) ? modelMem[a] : seedData(a);
        expBusWr.push_back(1'b0); expBusAddr.push_back(a); expBusData.push_back(32'h0);
        for (int b = 0; b < 4; b++)
          expOut.push_back({1'b0, (k == 0 && b == 0), (k == words - 1 && b == 3), d[8*b +: 8]});
      end
    end
    sendPkt();
    waitDone();
    check(errFlag == expErr, "R11", "error flag after good packet", errFlag, expErr);
  endtask

  task automatic runBad(string req);
    expErr = 1'b1;
    sendPkt();
    repeat (6) @(negedge clk);
    waitDone();
    check(errFlag == 1'b1, req, "dropped request flags error", errFlag, 1);
    check(inReady && !outValid && !busRead && !busWrite, req, "idle after drop",
          {inReady, outValid, busRead, busWrite}, 4'b1000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(errFlag == 1'b0 && inReady == 1'b1, "R11", "reset state", {errFlag, inReady}, 2'b01);
    check(!busRead && !busWrite && !outValid, "R6", "reset strobes", {busRead, busWrite, outValid}, 0);
    rstN = 1'b1;

    // R2 R3 single write then R4 read back
    runValid(8'h00, 16'd4, 32'h1234_5678, 32'hDEAD_BEEF);
    runValid(8'h04, 16'd4, 32'h0000_0100, 32'h0A0B_0C0D);
    runValid(8'h10, 16'd4, 32'h1234_5678, 32'h0);
    // R5 incrementing read over written and fresh words
    runValid(8'h14, 16'd16, 32'h0000_00F8, 32'h0);
    // R10 stray bytes between packets
    sendByte(8'h10, 1'b0, 1'b0); sendByte(8'h7F, 1'b0, 1'b1); sendByte(8'h00, 1'b0, 1'b0);
    runValid(8'h10, 16'd4, 32'h0000_0100, 32'h0);
    // R10 restart mid header
    sendByte(8'h10, 1'b1, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0);
    runValid(8'h10, 16'd4, 32'h0000_0040, 32'h0);
    // R10 restart mid payload
    buildHdr(8'h00, 16'd4, 32'h0000_0200);
    pkt.push_back(8'h11); pkt.push_back(8'h22);
    for (int i = 0; i < pkt.size(); i++) sendByte(pkt[i], i == 0, 1'b0);
    runValid(8'h00, 16'd4, 32'h0000_0300, 32'h7A7B_7C7D);
    // R5 largest read
    runValid(8'h14, 16'h0400, 32'h0000_2000, 32'h0);

    // R8 no-transaction and unknown opcodes
    buildHdr(8'h7F, 16'd4, 32'h0000_0040); runBad("R8");
    buildHdr(8'h33, 16'd4, 32'h0000_0040); runBad("R8");
    // R7 count limits
    buildHdr(8'h14, 16'h0404, 32'h0000_0040); runBad("R7");
    buildHdr(8'h14, 16'd6, 32'h0000_0040); runBad("R7");
    buildHdr(8'h14, 16'd0, 32'h0000_0040); runBad("R7");
    buildHdr(8'h10, 16'd8, 32'h0000_0040); runBad("R7");
    buildHdr(8'h00, 16'd8, 32'h0000_0040);
    for (int i = 0; i < 8; i++) pkt.push_back(8'(i));
    runBad("R7");
    // R9 framing errors
    buildHdr(8'h10, 16'd4, 32'h0000_0040); pkt = pkt[0:4]; runBad("R9");
    buildHdr(8'h00, 16'd4, 32'h0000_0040);
    for (int i = 0; i < 5; i++) pkt.push_back(8'(i + 1));
    runBad("R9");
    buildHdr(8'h10, 16'd4, 32'h0000_0040); pkt.push_back(8'h55); runBad("R9");
    // recovery, error stays set
    runValid(8'h10, 16'd4, 32'h0000_0300, 32'h0);

    check(expBusWr.size() == 0 && expOut.size() == 0, "R5", "queues drained",
          expBusWr.size() + expOut.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule